// File: doc/BRIEF.md
# Fractional Clock Divider with Edge Phase Error

This block turns one fast source clock into several slower clocks, each divided by its own fractional ratio N + num/den. No single integer divider can hit such a ratio. Each output period therefore lasts either N or N+1 source cycles. An error accumulator picks between the two so that the long-run frequency carries no error at all. A configurable number of channels, four by default, share the same source clock and run fully independently.

Each period starts with a falling edge of the divided clock. At that edge every channel also publishes the signed distance between the edge it produced and the ideal edge of an exact fractional divider. A downstream phase-correction stage can use this word to remove the deterministic jitter that the dithering leaves behind.

A channel changes its ratio through a per-channel load strobe. The new value waits in a pending slot and takes over only at a period boundary, so no period is ever cut short. The configuration pins are plain control inputs with no handshake. The outputs are plain levels that are valid on every cycle.

Top module: `frac_clk_div`

## Requirements
- R1: Every period of a channel lasts N or N+1 source cycles of the ratio in effect. It lasts N+1 exactly when (acc + num) >= den, where acc is the channel's accumulator at the start of that period.
- R2: From the period where a ratio takes over, any den consecutive periods add up to exactly N*den + num source cycles.
- R3: At each period start, phase_err equals -acc as an ERR_W-bit two's complement value, in units of 1/den source cycle. It therefore lies in (-den, 0]: the real edge is never later than the ideal one. From one period to the next, acc becomes acc + num, minus den if the period just ended was N+1 long.
- R4: phase_err changes only on the source edge where div_clk falls. At all other times it holds its value.
- R5: A period of length L starts with a low phase of L - floor(L/2) cycles, followed by a high phase of floor(L/2) cycles. With an odd L, the extra cycle falls in the low phase.
- R6: A legal load becomes the pending ratio. That ratio takes over at the first period boundary strictly after the edge that captured the load. There the accumulator restarts at 0 and phase_err reads 0. A later legal load made before that boundary replaces the pending one.
- R7: A load with N < 2, den = 0 or num >= den is ignored. The active ratio, the pending ratio and the running accumulator stay as they were.
- R8: With num = 0, every period is exactly N cycles and phase_err stays 0.
- R9: Loading or running one channel has no effect on the periods or phase_err of any other channel.
- R10: During reset, div_clk is low and phase_err is 0. Every channel starts with the ratio RST_INT + 0/1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock shared by all channels |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | NUM_CH | Per-channel load strobe for a new ratio |
| cfg_int | input | NUM_CH x INT_W | Integer part N of each channel's ratio |
| cfg_num | input | NUM_CH x FRAC_W | Numerator of the fractional part |
| cfg_den | input | NUM_CH x FRAC_W | Denominator of the fractional part |
| div_clk | output | NUM_CH | Divided clock of each channel |
| phase_err | output | NUM_CH x ERR_W | Signed edge error of each channel, in 1/den source cycles |

## Verification
The assertions assume the ratio inputs can never drive a period longer than 2^INT_W source cycles or shorter than two. The duty check assumes the low phase comes first in every period. Both follow from the legality filter, so the stimulus throws illegal loads at the channels on purpose: N of 0 or 1, a zero denominator, and a numerator at or above the denominator. It also sends random legal ratios with N between 2 and 24 and denominators small enough to watch whole den-period windows. One channel runs a near-2^30 denominator to exercise the full width of the accumulator and the error word. Back-to-back loads are timed to land inside a long period, so the pending replacement is tested.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  localparam int INT_W  = 8;
  localparam int FRAC_W = 30;
  localparam int CNT_W  = INT_W + 1;
  localparam int ERR_W  = FRAC_W + 1;

  typedef struct packed {
    logic [INT_W-1:0]  n;
    logic [FRAC_W-1:0] num;
    logic [FRAC_W-1:0] den;
  } ratio_t;

  function automatic logic ratio_ok(ratio_t r);
    return (r.n >= INT_W'(2)) && (r.den != '0) && (r.num < r.den);
  endfunction
endpackage

// File: rtl/fdiv_ratio_hold.sv
module fdiv_ratio_hold
  import fdiv_pkg::*;
#(
  parameter int RST_INT = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  ratio_t load_val,
  input  logic   boundary,
  output ratio_t nxt_ratio,
  output logic   adopt
);
  localparam ratio_t RST_RATIO = '{n: INT_W'(RST_INT), num: '0, den: FRAC_W'(1)};

  ratio_t act_q, pend_q;
  logic   pend_v_q;

  assign adopt     = boundary && pend_v_q;
  assign nxt_ratio = adopt ? pend_q : act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q    <= RST_RATIO;
      pend_q   <= RST_RATIO;
      pend_v_q <= 1'b0;
    end else begin
      if (adopt) begin
        act_q    <= pend_q;
        pend_v_q <= 1'b0;
      end
      if (load && ratio_ok(load_val)) begin
        pend_q   <= load_val;
        pend_v_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fdiv_err_accum.sv
module fdiv_err_accum
  import fdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary,
  input  logic              adopt,
  input  ratio_t            nxt_ratio,
  output logic              up_nxt,
  output logic [ERR_W-1:0]  phase_err
);
  logic [FRAC_W-1:0] acc_q;
  logic              up_q;
  logic [FRAC_W:0]   sum;
  logic [FRAC_W-1:0] acc_nxt;

  always_comb begin
    sum = {1'b0, acc_q} + {1'b0, nxt_ratio.num};
    if (up_q) sum = sum - {1'b0, nxt_ratio.den};
    acc_nxt = adopt ? '0 : sum[FRAC_W-1:0];
    up_nxt  = ({1'b0, acc_nxt} + {1'b0, nxt_ratio.num}) >= {1'b0, nxt_ratio.den};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      up_q  <= 1'b0;
    end else if (boundary) begin
      acc_q <= acc_nxt;
      up_q  <= up_nxt;
    end
  end

  assign phase_err = '0 - {1'b0, acc_q};
endmodule

// File: rtl/fdiv_wave_gen.sv
module fdiv_wave_gen
  import fdiv_pkg::*;
#(
  parameter int RST_INT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INT_W-1:0] n_nxt,
  input  logic             up_nxt,
  output logic             boundary,
  output logic             clk_out
);
  logic [CNT_W-1:0] cnt_q, len_q, cnt_n, len_n;
  logic             clk_n;

  assign boundary = (cnt_q == len_q - CNT_W'(1));

  always_comb begin
    if (boundary) begin
      cnt_n = '0;
      len_n = {1'b0, n_nxt} + CNT_W'(up_nxt);
      clk_n = 1'b0;
    end else begin
      cnt_n = cnt_q + CNT_W'(1);
      len_n = len_q;
      clk_n = cnt_n >= (len_q - (len_q >> 1));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      len_q   <= CNT_W'(RST_INT);
      clk_out <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      len_q   <= len_n;
      clk_out <= clk_n;
    end
  end
endmodule

// File: rtl/fdiv_channel.sv
module fdiv_channel
  import fdiv_pkg::*;
#(
  parameter int RST_INT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  ratio_t           load_val,
  output logic             clk_out,
  output logic [ERR_W-1:0] phase_err
);
  ratio_t nxt_ratio;
  logic   adopt, boundary, up_nxt;

  fdiv_ratio_hold #(.RST_INT(RST_INT)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
    .boundary(boundary), .nxt_ratio(nxt_ratio), .adopt(adopt)
  );

  fdiv_err_accum u_acc (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .adopt(adopt),
    .nxt_ratio(nxt_ratio), .up_nxt(up_nxt), .phase_err(phase_err)
  );

  fdiv_wave_gen #(.RST_INT(RST_INT)) u_wave (
    .clk(clk), .rst_n(rst_n), .n_nxt(nxt_ratio.n), .up_nxt(up_nxt),
    .boundary(boundary), .clk_out(clk_out)
  );
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
  import fdiv_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int RST_INT = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_CH-1:0]             cfg_load,
  input  logic [NUM_CH-1:0][INT_W-1:0]  cfg_int,
  input  logic [NUM_CH-1:0][FRAC_W-1:0] cfg_num,
  input  logic [NUM_CH-1:0][FRAC_W-1:0] cfg_den,
  output logic [NUM_CH-1:0]             div_clk,
  output logic [NUM_CH-1:0][ERR_W-1:0]  phase_err
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ratio_t val;
    assign val = '{n: cfg_int[c], num: cfg_num[c], den: cfg_den[c]};
    fdiv_channel #(.RST_INT(RST_INT)) u_ch (
      .clk(clk), .rst_n(rst_n), .load(cfg_load[c]), .load_val(val),
      .clk_out(div_clk[c]), .phase_err(phase_err[c])
    );
  end
endmodule

// File: rtl/fdiv_checker.sv
module fdiv_checker
  import fdiv_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NUM_CH-1:0]            div_clk,
  input logic [NUM_CH-1:0][ERR_W-1:0] phase_err
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    logic             prev_q, rise_seen_q;
    logic [CNT_W:0]   run_q, low_len_q;
    logic             fall_now;

    assign fall_now = prev_q && !div_clk[c];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prev_q      <= 1'b0;
        run_q       <= '0;
        low_len_q   <= '0;
        rise_seen_q <= 1'b0;
      end else begin
        prev_q <= div_clk[c];
        run_q  <= (div_clk[c] != prev_q) ? (CNT_W+1)'(1) : run_q + (CNT_W+1)'(1);
        if (div_clk[c] && !prev_q) begin
          low_len_q   <= run_q;
          rise_seen_q <= 1'b1;
        end
      end
    end

    // R1: whole period within the legal divide range
    a_r1_period_range: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_now && rise_seen_q) |-> ((low_len_q + run_q) >= (CNT_W+1)'(2)
                                  && (low_len_q + run_q) <= (CNT_W+1)'(1 << INT_W)));

    // R3: the real edge is never later than the ideal one
    a_r3_err_sign: assert property (@(posedge clk) disable iff (!rst_n)
      $signed(phase_err[c]) <= 0);

    // R4: the error word moves only at a falling edge of the divided clock
    a_r4_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(div_clk[c]) |-> $stable(phase_err[c]));

    // R5: low phase equals high phase or exceeds it by one cycle
    a_r5_duty_split: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_now && rise_seen_q) |-> (low_len_q == run_q || low_len_q == run_q + (CNT_W+1)'(1)));
  end
endmodule

bind frac_clk_div fdiv_checker #(.NUM_CH(NUM_CH)) u_fdiv_chk (
  .clk(clk), .rst_n(rst_n), .div_clk(div_clk), .phase_err(phase_err)
);

// File: tb/test_frac_clk_div.sv
`timescale 1ns/1ps
module test_frac_clk_div;
  import fdiv_pkg::*;
  localparam int NCH = 4;
  localparam int RST_INT = 2;
  localparam longint TRACK_MAX = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0]             cfg_load = '0;
  logic [NCH-1:0][INT_W-1:0]  cfg_int  = '0;
  logic [NCH-1:0][FRAC_W-1:0] cfg_num  = '0;
  logic [NCH-1:0][FRAC_W-1:0] cfg_den  = '0;
  logic [NCH-1:0]             div_clk;
  logic [NCH-1:0][ERR_W-1:0]  phase_err;

  frac_clk_div #(.NUM_CH(NCH), .RST_INT(RST_INT)) i_frac_clk_div (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_int(cfg_int),
    .cfg_num(cfg_num), .cfg_den(cfg_den), .div_clk(div_clk), .phase_err(phase_err)
  );

  always #2 clk = ~clk;

  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_err = 0;

  task automatic check(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // bench model of every channel, built from the requirements
  longint m_n[NCH], m_num[NCH], m_den[NCH], m_acc[NCH];
  longint p_n[NCH], p_num[NCH], p_den[NCH], p_cyc[NCH];
  bit     p_v[NCH], started[NCH], trk[NCH], e_up[NCH], prev_clk[NCH];
  longint e_len[NCH], sum[NCH], pcnt[NCH], last_fall[NCH], last_rise[NCH];

  function automatic bit legal(longint n, longint num, longint den);
    return (n >= 2) && (den != 0) && (num < den);
  endfunction

  initial begin
    for (int c = 0; c < NCH; c++) begin
      m_n[c] = RST_INT; m_num[c] = 0; m_den[c] = 1; m_acc[c] = 0;
      p_v[c] = 0; started[c] = 0; trk[c] = 0; prev_clk[c] = 0;
      e_up[c] = 0; e_len[c] = RST_INT; sum[c] = 0; pcnt[c] = 0;
      last_fall[c] = 0; last_rise[c] = 0; p_cyc[c] = 0;
      p_n[c] = 0; p_num[c] = 0; p_den[c] = 1;
    end
  end

  task automatic on_fall(int c);
    longint per, hi, got;
    bit adopted;
    adopted = 0;
    if (started[c]) begin
      per = cyc - last_fall[c];
      hi  = cyc - last_rise[c];
      check(per == e_len[c], $sformatf("R1 R9 ch%0d period", c), per, e_len[c]);
      check(hi == e_len[c] / 2, $sformatf("R5 ch%0d high phase", c), hi, e_len[c] / 2);
      if (m_num[c] == 0)
        check(per == m_n[c], $sformatf("R8 ch%0d integer period", c), per, m_n[c]);
      if (trk[c]) begin
        sum[c] += per; pcnt[c]++;
        if (pcnt[c] == m_den[c]) begin
          check(sum[c] == m_n[c] * m_den[c] + m_num[c], $sformatf("R2 ch%0d window total", c),
                sum[c], m_n[c] * m_den[c] + m_num[c]);
          trk[c] = 0;
        end
      end
    end
    if (p_v[c] && cyc > p_cyc[c]) begin
      m_n[c] = p_n[c]; m_num[c] = p_num[c]; m_den[c] = p_den[c];
      m_acc[c] = 0; p_v[c] = 0; adopted = 1;
      trk[c] = (m_den[c] <= TRACK_MAX); sum[c] = 0; pcnt[c] = 0;
    end else if (started[c]) begin
      m_acc[c] = m_acc[c] + m_num[c] - (e_up[c] ? m_den[c] : 0);
    end
    started[c] = 1;
    e_up[c]  = (m_acc[c] + m_num[c]) >= m_den[c];
    e_len[c] = m_n[c] + (e_up[c] ? 1 : 0);
    last_fall[c] = cyc;
    got = $signed(phase_err[c]);
    check(got == -m_acc[c], $sformatf("%s ch%0d phase error", adopted ? "R6" : "R3", c), got, -m_acc[c]);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        if (div_clk[c] && !prev_clk[c]) last_rise[c] = cyc;
        if (!div_clk[c] && prev_clk[c]) on_fall(c);
        prev_clk[c] = div_clk[c];
      end
    end
  end

  task automatic load(int c, longint n, longint num, longint den);
    @(negedge clk);
    cfg_load[c] = 1'b1;
    cfg_int[c]  = n[INT_W-1:0];
    cfg_num[c]  = num[FRAC_W-1:0];
    cfg_den[c]  = den[FRAC_W-1:0];
    @(negedge clk);
    cfg_load[c] = 1'b0;
    if (legal(n, num, den)) begin
      p_v[c] = 1; p_n[c] = n; p_num[c] = num; p_den[c] = den; p_cyc[c] = cyc;
    end
  endtask

  function automatic bit busy();
    for (int c = 0; c < NCH; c++) if (p_v[c] || trk[c]) return 1;
    return 0;
  endfunction

  task automatic settle(int min_cyc);
    longint t0;
    t0 = cyc;
    repeat (min_cyc) @(negedge clk);
    while (busy()) begin
      @(negedge clk);
      if (cyc - t0 > 60000) begin
        check(0, "R2 settle timeout", cyc - t0, 60000);
        break;
      end
    end
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_err++;
    $display("FAIL watchdog expired R2 actual=%0d expected=%0d", cyc, 200000);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int unsigned seed;
    longint n, num, den;
    seed = $urandom(32'd1357);
    // R10 reset state
    repeat (4) @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      check(div_clk[c] == 1'b0, $sformatf("R10 ch%0d clk in reset", c), div_clk[c], 0);
      check($signed(phase_err[c]) == 0, $sformatf("R10 ch%0d err in reset", c), $signed(phase_err[c]), 0);
    end
    rst_n = 1'b1;
    repeat (20) @(negedge clk);

    // directed: 2.5, integer 5, large N, full-width fraction
    load(0, 2, 1, 2);
    load(1, 5, 0, 7);
    load(2, 255, 29, 30);
    load(3, 3, (1 << 30) - 2, (1 << 30) - 1);
    settle(400);

    // R7 illegal loads on each channel: nothing may change
    load(0, 1, 0, 1);
    load(1, 4, 0, 0);
    load(2, 6, 9, 9);
    load(3, 0, 1, 3);
    settle(200);

    // R6 pending replacement inside a long period
    load(0, 60, 0, 1);
    settle(200);
    load(0, 3, 0, 1);
    load(0, 4, 1, 3);
    settle(100);

    // R9 one channel only
    load(2, 7, 3, 11);
    settle(50);

    // constrained random rounds
    for (int r = 0; r < 12; r++) begin
      for (int c = 0; c < NCH; c++) begin
        if ($urandom_range(0, 1) == 1) begin
          n   = $urandom_range(2, 24);
          den = $urandom_range(1, 40);
          num = $urandom_range(0, int'(den) - 1);
          case ($urandom_range(0, 7))
            0: n = $urandom_range(0, 1);
            1: num = den + $urandom_range(0, 3);
            2: den = 0;
            default: ;
          endcase
          load(c, n, num, den);
        end
      end
      settle(60);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule